// File: doc/BRIEF.md
# Multiplexed Row Scanner with Dimming

This block drives a row-multiplexed LED dot array of ten 5x5 characters. One clock-enable pulse, picked from either an internal oscillator enable or an external multiplex tick, advances a scan position. A frame is 320 scan counts, split into five row slots of 64 counts each. During a slot the block puts out the address of the current row to the dot RAM. It then drives that row's strobe line together with 50 column outputs: five columns for each of the ten characters.

Brightness comes from the duty factor of each row strobe. The strobe is on from the start of its slot for a number of counts set by a three-bit code, and blank for the rest of the slot. Lamp test lights every column at the 53% level, whatever the RAM holds. Power down blanks the array and freezes the scan counter. A synchronous active-low reset returns the scan to row 0, count 0, so that several arrays can be brought into step. The outputs are registered. They reflect the scan state and the inputs one clock earlier.

Top module: `dotrow_scan`

## Requirements
- R1: When `rst_n` is low at a clock edge, `row_drv` and `col_drv` go to zero and `ram_row` goes to 0. The scan restarts at count 0 of row 0.
- R2: Each active tick moves the scan count on by one. After 64 counts in a slot, the scan moves to the next row in the order 0,1,2,3,4,0. `ram_row` always shows the current row.
- R3: At most one bit of `row_drv` is high. When bit k is high, it is the row that `ram_row` showed in the cycle before.
- R4: While a row is lit and lamp test is off, `col_drv` equals the `ram_data` that was present for that row in the previous cycle. Bit 5*c+j is column j of character c.
- R5: `bright_code` selects how many counts the row is on, counted from slot count 0. The codes 0 to 6 give 64, 34, 26, 17, 13, 8 and 4 counts. Code 7 keeps the array dark.
- R6: The row is dark in the last count (63) of every slot, whatever the brightness, so that two rows never overlap.
- R7: With `lamp_test` high, `bright_code` is ignored and all 50 columns are driven high for 34 counts of each slot.
- R8: With `power_down` high, `row_drv` and `col_drv` are zero. The scan count and the row do not move.
- R9: `clk_sel` high makes `osc_tick` the active tick and `clk_sel` low makes `ext_tick` the active tick. The tick that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 1 | 1 = use osc_tick, 0 = use ext_tick |
| osc_tick | input | 1 | Internal oscillator scan enable |
| ext_tick | input | 1 | External multiplex scan enable |
| bright_code | input | 3 | Duty code, 0 brightest, 7 dark |
| lamp_test | input | 1 | Light all dots at the 53% duty |
| power_down | input | 1 | Blank the array and freeze the scan |
| ram_row | output | 3 | Row address to the dot RAM |
| ram_data | input | 50 | Column bits returned for `ram_row` |
| row_drv | output | 5 | Row strobe lines, one-hot or zero |
| col_drv | output | 50 | Column drive lines |

## Verification
The assertions check on every cycle that the row strobes are one-hot or zero. They also check that the scan wraps from count 63 to the next slot, that power down freezes the scan and darkens the outputs in the next cycle, that lamp test drives every column while a row is lit, and that the cycle after count 63 is always dark. Other behaviours only the bench scenarios can show, because they depend on an exact count. These are the on-time for each brightness code, that the row order and the `ram_row` address track a full 320-count frame, that the column data match the RAM row by row, and that the unselected tick is ignored.

// File: rtl/dscan_pkg.sv
// Package: shared helpers for the row scanner.
// Assumes slot length is a power of two scaled from a 64-count base.
package dscan_pkg;

    // On-time in counts for a duty code, scaled from a 64-count slot.
    function automatic int unsigned on_counts(input logic [2:0] code, input int unsigned slot_len);
        int unsigned base;
        case (code)
            3'd0:    base = 64;
            3'd1:    base = 34;
            3'd2:    base = 26;
            3'd3:    base = 17;
            3'd4:    base = 13;
            3'd5:    base = 8;
            3'd6:    base = 4;
            default: base = 0;
        endcase
        return (base * slot_len) / 64;
    endfunction

    // Duty code that lamp test uses (the 53% level).
    localparam logic [2:0] LAMP_CODE = 3'd1;

endpackage

// File: rtl/dscan_divider.sv
// Module: scan divider. Picks the active tick and steps a slot counter
// and a row index through NUM_ROWS slots of SLOT_COUNTS counts.
// Assumes the tick inputs are one-cycle enables synchronous to clk.
module dscan_divider #(
    parameter int NUM_ROWS    = 5,
    parameter int SLOT_COUNTS = 64,
    localparam int SLOT_W     = $clog2(SLOT_COUNTS),
    localparam int ROW_W      = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic              osc_tick,
    input  logic              ext_tick,
    input  logic              power_down,
    output logic [SLOT_W-1:0] slot_cnt,
    output logic [ROW_W-1:0]  row_idx
);

    logic advance;

    // Select the tick source and gate it with power down.
    always_comb begin
        advance = (clk_sel ? osc_tick : ext_tick) && !power_down;
    end

    // Step the count inside a slot and the row at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            row_idx  <= '0;
        end else if (advance) begin
            if (slot_cnt == SLOT_W'(SLOT_COUNTS - 1)) begin
                slot_cnt <= '0;
                row_idx  <= (row_idx == ROW_W'(NUM_ROWS - 1)) ? '0 : row_idx + 1'b1;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    // R2: the slot counter wraps to zero after its last count.
    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && slot_cnt == SLOT_W'(SLOT_COUNTS - 1)) |=> slot_cnt == '0);

    // R2: the row index stays within range.
    p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx < ROW_W'(NUM_ROWS));

    // R8: power down freezes the scan position.
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> ($stable(slot_cnt) && $stable(row_idx)));

endmodule

// File: rtl/dscan_duty.sv
// Module: duty gate. Decides whether the current row is lit at this
// slot count, from the duty code, lamp test and power down.
// Assumes slot_cnt counts from 0 at the start of each slot.
module dscan_duty
    import dscan_pkg::*;
#(
    parameter int SLOT_COUNTS = 64,
    localparam int SLOT_W     = $clog2(SLOT_COUNTS)
) (
    input  logic [SLOT_W-1:0] slot_cnt,
    input  logic [2:0]        bright_code,
    input  logic              lamp_test,
    input  logic              power_down,
    output logic              lit
);

    logic [SLOT_W:0] on_len;

    // Pick the on-time and compare it with the slot position.
    always_comb begin
        on_len = (SLOT_W + 1)'(on_counts(lamp_test ? LAMP_CODE : bright_code, SLOT_COUNTS));
        lit    = !power_down
              && ({1'b0, slot_cnt} < on_len)
              && (slot_cnt != SLOT_W'(SLOT_COUNTS - 1));
    end

endmodule

// File: rtl/dscan_drive.sv
// Module: output register stage. Registers the row strobe and the
// column lines from the lit flag, the row index and the RAM data.
// Assumes ram_data belongs to row_idx in the same cycle.
module dscan_drive #(
    parameter int NUM_ROWS = 5,
    parameter int DATA_W   = 50,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lit,
    input  logic                lamp_test,
    input  logic                power_down,
    input  logic [ROW_W-1:0]    row_idx,
    input  logic [DATA_W-1:0]   ram_data,
    output logic [NUM_ROWS-1:0] row_drv,
    output logic [DATA_W-1:0]   col_drv
);

    // Register the row strobe and the column pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_drv <= '0;
            col_drv <= '0;
        end else if (lit) begin
            row_drv <= NUM_ROWS'(1) << row_idx;
            col_drv <= lamp_test ? {DATA_W{1'b1}} : ram_data;
        end else begin
            row_drv <= '0;
            col_drv <= '0;
        end
    end

    // R3: never more than one row strobe at a time.
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_drv));

    // R7: lamp test drives every column while lit.
    p_lamp_cols_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_test && lit) |=> (&col_drv));

    // R8: power down darkens every output.
    p_pd_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (row_drv == '0 && col_drv == '0));

endmodule

// File: rtl/dotrow_scan.sv
// Module: top of the multiplexed row scanner with dimming.
// Scans NUM_ROWS rows of NUM_CHARS characters of NUM_COLS dots. It
// reads one RAM row at a time through ram_row/ram_data (read with no
// latency) and drives registered row and column lines.
module dotrow_scan #(
    parameter int NUM_CHARS   = 10,
    parameter int NUM_COLS    = 5,
    parameter int NUM_ROWS    = 5,
    parameter int SLOT_COUNTS = 64,
    localparam int DATA_W     = NUM_CHARS * NUM_COLS,
    localparam int SLOT_W     = $clog2(SLOT_COUNTS),
    localparam int ROW_W      = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_sel,
    input  logic                osc_tick,
    input  logic                ext_tick,
    input  logic [2:0]          bright_code,
    input  logic                lamp_test,
    input  logic                power_down,
    output logic [ROW_W-1:0]    ram_row,
    input  logic [DATA_W-1:0]   ram_data,
    output logic [NUM_ROWS-1:0] row_drv,
    output logic [DATA_W-1:0]   col_drv
);

    logic [SLOT_W-1:0] slot_cnt;
    logic [ROW_W-1:0]  row_idx;
    logic              lit;

    dscan_divider #(.NUM_ROWS(NUM_ROWS), .SLOT_COUNTS(SLOT_COUNTS)) u_div (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .osc_tick(osc_tick),
        .ext_tick(ext_tick), .power_down(power_down),
        .slot_cnt(slot_cnt), .row_idx(row_idx)
    );

    dscan_duty #(.SLOT_COUNTS(SLOT_COUNTS)) u_duty (
        .slot_cnt(slot_cnt), .bright_code(bright_code), .lamp_test(lamp_test),
        .power_down(power_down), .lit(lit)
    );

    dscan_drive #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .lit(lit), .lamp_test(lamp_test),
        .power_down(power_down), .row_idx(row_idx), .ram_data(ram_data),
        .row_drv(row_drv), .col_drv(col_drv)
    );

    // Row address to the RAM follows the scan row.
    always_comb begin
        ram_row = row_idx;
    end

    // R6: the cycle after the last slot count is always dark.
    p_ghost_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt == SLOT_W'(SLOT_COUNTS - 1)) |=> row_drv == '0);

endmodule

// File: tb/sim_dotrow_scan.sv
module sim_dotrow_scan;

    localparam int DW = 50;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_sel, osc_tick, ext_tick, lamp_test, power_down;
    logic [2:0]    bright_code;
    logic [2:0]    ram_row;
    logic [DW-1:0] ram_data;
    logic [4:0]    row_drv;
    logic [DW-1:0] col_drv;

    int checks = 0;
    int errors = 0;

    // Model state
    int m_slot = 0;
    int m_row  = 0;

    always #4 clk = ~clk;

    dotrow_scan u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .osc_tick(osc_tick),
        .ext_tick(ext_tick), .bright_code(bright_code), .lamp_test(lamp_test),
        .power_down(power_down), .ram_row(ram_row), .ram_data(ram_data),
        .row_drv(row_drv), .col_drv(col_drv)
    );

    function automatic logic [DW-1:0] rowpat(input int r);
        return {10{5'(r * 6 + 1)}} ^ 50'h0_5A5A_3C3C_0F0F;
    endfunction

    assign ram_data = rowpat(int'(ram_row));

    function automatic int on_len(input int code);
        case (code)
            0: return 64; 1: return 34; 2: return 26; 3: return 17;
            4: return 13; 5: return 8;  6: return 4;  default: return 0;
        endcase
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            4: return "R4";
            5: return "R5";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Fields: sel osc ext code[3] lamp pd tag[4] cycles[9]
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 4'd5, 9'd330},
        {1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 4'd5, 9'd330},
        {1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd5, 9'd200},
        {1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 4'd5, 9'd200},
        {1'b1, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, 4'd5, 9'd330},
        {1'b1, 1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 4'd5, 9'd200},
        {1'b1, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0, 4'd7, 9'd330},
        {1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 4'd8, 9'd100},
        {1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd9, 9'd330},
        {1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 4'd9, 9'd100},
        {1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd9, 9'd100},
        {1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 4'd4, 9'd330}
    };

    // One cycle: predict, clock, update model, check at the negedge.
    task automatic step(input string req);
        int len;
        bit lit, adv, was_last;
        logic [4:0]    e_row;
        logic [DW-1:0] e_col;
        len      = on_len(lamp_test ? 1 : int'(bright_code));
        lit      = !power_down && m_slot < len && m_slot != 63;
        was_last = (m_slot == 63);
        e_row    = lit ? (5'd1 << m_row) : 5'd0;
        e_col    = lit ? (lamp_test ? {DW{1'b1}} : rowpat(m_row)) : '0;
        adv      = (clk_sel ? osc_tick : ext_tick) && !power_down;
        @(posedge clk);
        if (adv) begin
            if (m_slot == 63) begin
                m_slot = 0;
                m_row  = (m_row == 4) ? 0 : m_row + 1;
            end else m_slot = m_slot + 1;
        end
        @(negedge clk);
        chk(row_drv == e_row && col_drv == e_col, req, "rows/cols",
            {9'd0, row_drv, col_drv}, {9'd0, e_row, e_col});
        chk(int'(ram_row) == m_row, "R2", "ram_row", 64'(ram_row), 64'(m_row));
        chk($countones(row_drv) <= 1, "R3", "onehot row", 64'(row_drv), 64'(e_row));
        if (was_last)
            chk(row_drv == 5'd0, "R6", "dark last count", 64'(row_drv), 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        m_slot = 0;
        m_row  = 0;
        @(negedge clk);
        chk(row_drv == 5'd0 && col_drv == '0, "R1", "outputs in reset",
            {9'd0, row_drv, col_drv}, 64'd0);
        chk(ram_row == 3'd0, "R1", "ram_row in reset", 64'(ram_row), 64'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_sel = 1'b1; osc_tick = 1'b1; ext_tick = 1'b0;
        bright_code = 3'd0; lamp_test = 1'b0; power_down = 1'b0;
        @(negedge clk);
        do_reset();
        for (int v = 0; v < NV; v++) begin
            clk_sel     = VEC[v][20];
            osc_tick    = VEC[v][19];
            ext_tick    = VEC[v][18];
            bright_code = VEC[v][17:15];
            lamp_test   = VEC[v][14];
            power_down  = VEC[v][13];
            for (int c = 0; c < int'(VEC[v][8:0]); c++) step(tag_name(int'(VEC[v][12:9])));
        end
        // R1: a reset in mid-frame restarts the scan at row 0, count 0.
        clk_sel = 1'b1; osc_tick = 1'b1; ext_tick = 1'b0;
        bright_code = 3'd0; lamp_test = 1'b0; power_down = 1'b0;
        do_reset();
        for (int c = 0; c < 70; c++) step("R1");
        // R8: power down entered while a row is lit, then released.
        power_down = 1'b1;
        for (int c = 0; c < 5; c++) step("R8");
        power_down = 1'b0;
        for (int c = 0; c < 10; c++) step("R8");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule